// File: doc/BRIEF.md
# Multi-Mode Transfer Count Unit

This unit holds the 16-bit transfer count of a data-transfer engine. The count is loaded through a dedicated port and is not visible to software. A per-transfer decrement pulse then moves it down by one for each data unit moved. The mode is captured along with the value at load time, and it decides how the 16 bits are read.

In normal mode the whole register is one down counter, and a loaded zero stands for 65,536 transfers. When the counter reaches zero, the unit first emits a pulse that clears the activating source's enable bit. One clock later it raises a CPU interrupt pulse.

In repeat and block modes the register is split into two bytes. The upper byte is a fixed reload value (the repeat length or the block size). The lower byte counts down, and a zero in either byte stands for 256. When the lower byte would reach zero, it is refilled from the upper byte and a one-cycle reload pulse is emitted instead of an interrupt.

Top module: `xfer_count_unit`

## Requirements
- R1: While rst_ni is low and after its release, count_o is 0x0000, the captured mode is normal, and en_clr_o, irq_o and reload_o are low.
- R2: A cycle with load_i high places load_val_i on count_o from the next cycle on and captures mode_i: 2'b00 normal, 2'b01 repeat, 2'b10 block, 2'b11 treated as normal.
- R3: When load_i and dec_i are high in the same cycle, the load takes effect, the decrement is ignored, and no event pulse follows that cycle.
- R4: In normal mode each accepted decrement lowers the full 16-bit count by one, and a decrement at 0x0000 gives 0xFFFF with no event; a loaded 0x0000 therefore ends after exactly 65,536 decrements.
- R5: In normal mode a decrement at 0x0001 makes count_o 0x0000 and raises en_clr_o for exactly one cycle, in the same cycle in which count_o first shows 0x0000.
- R6: irq_o is a one-cycle pulse that is high exactly one clock after each en_clr_o pulse and at no other time.
- R7: In repeat or block mode a decrement changes only count_o[7:0], leaving count_o[15:8] unchanged, and a decrement with count_o[7:0] at 0x00 gives 0xFF with no event.
- R8: In repeat or block mode a decrement with count_o[7:0] at 0x01 copies count_o[15:8] into count_o[7:0] and raises reload_o for one cycle, in the same cycle the new value appears; en_clr_o and irq_o stay low.
- R9: In a split mode with upper byte 0x00 and lower byte 0x00, reload_o fires once per 256 decrements.
- R10: With load_i and dec_i both low, count_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the count and mode |
| load_val_i | input | 16 | Initial count value |
| mode_i | input | 2 | Mode captured with the load |
| dec_i | input | 1 | One pulse per data unit transferred |
| count_o | output | 16 | Current count register |
| reload_o | output | 1 | Split-mode reload pulse |
| en_clr_o | output | 1 | Clear pulse for the activating source's enable bit |
| irq_o | output | 1 | CPU interrupt request pulse |

## Verification
Two functions can fall in the same cycle: a load and a decrement. The stimulus forces this pairing both directly and at random. It also places a load right on top of a terminal decrement and right after one. Each such cycle is judged at the ports. The loaded value must appear unaltered, no reload or enable-clear pulse may follow, and an interrupt still owed from an earlier end event must arrive on time.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic [1:0] {
    XFC_NORMAL = 2'b00,
    XFC_REPEAT = 2'b01,
    XFC_BLOCK  = 2'b10,
    XFC_RSVD   = 2'b11
  } xfc_mode_e;

  function automatic logic is_split(xfc_mode_e m);
    return (m == XFC_REPEAT) || (m == XFC_BLOCK);
  endfunction
endpackage

// File: rtl/xfc_full_step.sv
module xfc_full_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             end_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    nxt_o = cnt_i - ONE;
    end_o = (cnt_i == ONE);
  end
endmodule

// File: rtl/xfc_split_step.sv
module xfc_split_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             reload_o
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] hi, lo, lo_nxt;

  always_comb begin
    hi       = cnt_i[CNT_W-1:HALF_W];
    lo       = cnt_i[HALF_W-1:0];
    reload_o = (lo == ONE);
    // reaching zero refills from the reload byte
    lo_nxt   = reload_o ? hi : lo - ONE;
    nxt_o    = {hi, lo_nxt};
  end
endmodule

// File: rtl/xfc_evt_pipe.sv
module xfc_evt_pipe #(
  parameter int IRQ_LAG = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic end_i,
  input  logic rel_i,
  output logic en_clr_o,
  output logic reload_o,
  output logic irq_o
);
  logic [IRQ_LAG-1:0] irq_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_clr_o <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      en_clr_o <= end_i;
      reload_o <= rel_i;
    end
  end

  generate
    if (IRQ_LAG == 1) begin : g_lag1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_sr <= '0;
        else         irq_sr <= en_clr_o;
      end
    end else begin : g_lagn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_sr <= '0;
        else         irq_sr <= {irq_sr[IRQ_LAG-2:0], en_clr_o};
      end
    end
  endgenerate

  assign irq_o = irq_sr[IRQ_LAG-1];
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xfc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int IRQ_LAG = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [1:0]       mode_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reload_o,
  output logic             en_clr_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, full_nxt, split_nxt;
  xfc_mode_e        mode_q;
  logic             full_end, split_rel, split_mode, dec_ok;

  assign split_mode = is_split(mode_q);
  assign dec_ok     = dec_i & ~load_i;

  xfc_full_step #(.CNT_W(CNT_W)) u_full (
    .cnt_i (cnt_q),
    .nxt_o (full_nxt),
    .end_o (full_end)
  );

  xfc_split_step #(.CNT_W(CNT_W)) u_split (
    .cnt_i    (cnt_q),
    .nxt_o    (split_nxt),
    .reload_o (split_rel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= XFC_NORMAL;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      mode_q <= xfc_mode_e'(mode_i);
    end else if (dec_i) begin
      cnt_q  <= split_mode ? split_nxt : full_nxt;
    end
  end

  xfc_evt_pipe #(.IRQ_LAG(IRQ_LAG)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .end_i    (dec_ok & ~split_mode & full_end),
    .rel_i    (dec_ok & split_mode & split_rel),
    .en_clr_o (en_clr_o),
    .reload_o (reload_o),
    .irq_o    (irq_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             dec_i,
  input logic [CNT_W-1:0] count_o,
  input logic             reload_o,
  input logic             en_clr_o,
  input logic             irq_o
);
  localparam int HALF_W = CNT_W / 2;

  assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));

  assert_load_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && dec_i) |=> (!en_clr_o && !reload_o));

  assert_end_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_o |-> count_o == '0);

  assert_irq_after_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_o |=> irq_o);

  assert_irq_only_after_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_clr_o));

  assert_reload_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> count_o[HALF_W-1:0] == count_o[CNT_W-1:HALF_W]);

  assert_reload_no_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reload_o && en_clr_o));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(count_o));
endmodule

bind xfer_count_unit xfc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .dec_i      (dec_i),
  .count_o    (count_o),
  .reload_o   (reload_o),
  .en_clr_o   (en_clr_o),
  .irq_o      (irq_o)
);

// File: tb/xfer_count_unit_test.sv
`timescale 1ns/1ps
module xfer_count_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, dec = 1'b0;
  logic [15:0] load_val = '0;
  logic [1:0]  mode = '0;
  logic [15:0] count;
  logic        reload, en_clr, irq;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic [1:0]  m_mode = '0;
  logic        m_en = 0, m_irq = 0, m_rel = 0;

  always #4 clk = ~clk;

  xfer_count_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_val_i(load_val),
    .mode_i(mode), .dec_i(dec), .count_o(count), .reload_o(reload),
    .en_clr_o(en_clr), .irq_o(irq)
  );

  function automatic bit split_m(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string cnt_tag(logic [1:0] m);
    return split_m(m) ? "R7 count" : "R4 count";
  endfunction

  // one clock: drive at negedge, model, compare at next negedge
  task automatic cyc(logic l, logic [15:0] v, logic [1:0] m, logic d);
    logic [7:0] lo;
    load = l; load_val = v; mode = m; dec = d;
    m_irq = m_en; m_en = 0; m_rel = 0;
    if (l) begin
      m_cnt = v; m_mode = m;
    end else if (d) begin
      if (split_m(m_mode)) begin
        lo = m_cnt[7:0];
        if (lo == 8'h01) begin lo = m_cnt[15:8]; m_rel = 1; end
        else lo = lo - 8'h01;
        m_cnt[7:0] = lo;
      end else begin
        if (m_cnt == 16'h0001) m_en = 1;
        m_cnt = m_cnt - 16'h0001;
      end
    end
    @(posedge clk); @(negedge clk);
    chk(l ? "R2 count" : (d ? cnt_tag(m_mode) : "R10 count"), count, m_cnt);
    chk("R5 en_clr", {15'd0, en_clr}, {15'd0, m_en});
    chk("R6 irq", {15'd0, irq}, {15'd0, m_irq});
    chk("R8 reload", {15'd0, reload}, {15'd0, m_rel});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rels;
    int ens;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 16'h0000);
    chk("R1 events in reset", {13'd0, en_clr, irq, reload}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", count, 16'h0000);

    // reset mode is normal: dec at 0 wraps, no event (R1, R4)
    cyc(0, 0, 2'b01, 1);
    chk("R4 wrap to FFFF", count, 16'hFFFF);

    // normal end, load on next cycle keeps irq owed (R5, R6, R3)
    cyc(1, 16'h0002, 2'b00, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R5 en_clr at zero", {15'd0, en_clr}, 16'd1);
    cyc(1, 16'h0001, 2'b11, 1);
    chk("R6 irq after clr", {15'd0, irq}, 16'd1);
    chk("R3 load wins", count, 16'h0001);
    cyc(0, 0, 0, 1);
    chk("R2 mode 11 acts normal R5", {15'd0, en_clr}, 16'd1);
    cyc(0, 0, 0, 0);

    // load with dec at terminal split value: no reload (R3)
    cyc(1, 16'h0501, 2'b01, 0);
    cyc(1, 16'h0301, 2'b10, 1);
    chk("R3 no reload on load+dec", {15'd0, reload}, 16'd0);
    cyc(0, 0, 0, 1);
    chk("R8 reload value", count, 16'h0303);
    chk("R8 reload pulse", {15'd0, reload}, 16'd1);
    // low byte zero wraps to FF (R7)
    cyc(1, 16'h0700, 2'b01, 0);
    cyc(0, 0, 0, 1);
    chk("R7 low wrap", count, 16'h07FF);

    // R9: 256-period split reload
    cyc(1, 16'h0000, 2'b10, 0);
    rels = 0;
    for (int i = 0; i < 512; i++) begin
      cyc(0, 0, 0, 1);
      if (reload) rels++;
    end
    chk("R9 reloads per 512 decs", 16'(rels), 16'd2);

    // R4: loaded zero lasts 65536 decrements
    cyc(1, 16'h0000, 2'b00, 0);
    ens = 0;
    for (int i = 0; i < 65535; i++) begin
      cyc(0, 0, 0, 1);
      if (en_clr) ens++;
    end
    chk("R4 no end before 65536", 16'(ens), 16'd0);
    cyc(0, 0, 0, 1);
    chk("R4 end at 65536", {15'd0, en_clr}, 16'd1);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      logic        l, d;
      logic [15:0] v;
      l = ($urandom % 16) == 0;
      d = ($urandom % 3) != 0;
      v = {8'($urandom % 5), 8'($urandom % 6)};
      if (($urandom % 4) == 0) v = 16'($urandom);
      cyc(l, v, 2'($urandom), d);
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule